// File: doc/BRIEF.md
# Streamed Configuration Image Loader

This block accepts a fixed-length configuration image from a host, one byte per write strobe. Each accepted byte goes to a configuration memory, at an address one above the previous byte's address. The host sees three status bits and a byte counter at all times.

After reset, the host waits for the ready flag. It then writes the whole image, including the two trailing checksum bytes. It then reads the completion flag and the checksum verdict. Bytes offered before ready, or after the image is complete, are dropped without effect. A bad verdict stays latched. The only way to retry is a reset, which clears every flag and starts the process again.

The reset input is asynchronous and active low. It is released into the block through a short synchronizer. A small timer then holds the ready flag low for a fixed number of cycles.

Top module: `cfg_stream_loader`

## Requirements
- R1: While reset is asserted, and after it is released: `bus_ready`, `load_done`, `crc_ok` and `mem_we` are 0 and `byte_count` is 0.
- R2: With default parameters, `bus_ready` is still 0 after the 5th rising clock edge following reset release. It is 1 after the 6th edge (2 synchronizer stages plus 4 delay cycles), and it stays 1 until the next reset.
- R3: A write strobe sampled while `bus_ready` is 0 is dropped: `byte_count` stays 0 and `mem_we` stays 0.
- R4: A write strobe sampled with `bus_ready` = 1 and `load_done` = 0 is accepted. In the next cycle `mem_we` = 1, `mem_addr` equals the count before the write, `mem_wdata` equals the written byte, and `byte_count` has grown by one.
- R5: `byte_count` reports the accepted bytes at any time. It never exceeds the image length of 10496.
- R6: `load_done` becomes 1 in the cycle after the 10496th byte is accepted, and is 0 before that.
- R7: Once `load_done` is 1, write strobes are dropped: `mem_we` stays 0, and `byte_count` and `crc_ok` keep their values.
- R8: The checksum is CRC-16, polynomial 0x1021, seed 0xFFFF, MSB first, with no reflection and no final XOR. It covers all 10496 bytes, and the last two bytes are the CRC of the first 10494 bytes, high byte first. When the CRC of all 10496 bytes is zero, `crc_ok` is 1 together with `load_done`.
- R9: If any byte is corrupted, `crc_ok` is 0 while `load_done` is 1. The verdict cannot change until reset.
- R10: A reset after a completed load clears `load_done`, `crc_ok` and `byte_count`, and a new load can start.
- R11: A cycle with `wr_en` = 0 during a load is not counted and gives `mem_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write strobe from bus decode |
| wr_data | input | 8 | Byte to load |
| bus_ready | output | 1 | Block accepts image bytes |
| load_done | output | 1 | Whole image received |
| crc_ok | output | 1 | Checksum verdict, valid when load_done is 1 |
| byte_count | output | 14 | Number of accepted bytes |
| mem_we | output | 1 | Configuration memory write enable |
| mem_addr | output | 14 | Configuration memory address |
| mem_wdata | output | 8 | Configuration memory write data |

## Verification
The full image is streamed twice.

The first stream is a valid image sent mostly back-to-back, with idle cycles inserted at intervals. This separates true counting and addressing from any sensitivity to `wr_en` timing, and it gives a passing verdict.

The second stream is sent back-to-back with one corrupted byte in the middle. It must still complete but give a failing verdict, which shows that the verdict depends on the data and not only on the count.

Writes are also offered during the ready delay and after completion. The count, the memory strobe and the verdict must stay untouched at those times, and a reset must clear the latched verdict.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // One byte of CRC-16 update, MSB first, byte folded into top half first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
`timescale 1ns/1ps
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_ready_timer.sv
`timescale 1ns/1ps
module cfg_ready_timer #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int TW = (DLY < 2) ? 1 : $clog2(DLY);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!rdy_q) begin
      if (cnt_q == TW'(DLY - 1)) rdy_d = 1'b1;
      else                       cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/cfg_crc16.sv
`timescale 1ns/1ps
module cfg_crc16
  import cfg_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_nxt
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_nxt = crc16_step(crc_q, din);
    crc_d   = en ? crc_nxt : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/cfg_stream_loader.sv
`timescale 1ns/1ps
module cfg_stream_loader #(
  parameter int IMG_LEN     = 10496,
  parameter int READY_DLY   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(IMG_LEN + 1),
  localparam int ADDR_W     = $clog2(IMG_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              bus_ready,
  output logic              load_done,
  output logic              crc_ok,
  output logic [CNT_W-1:0]  byte_count,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic rst_n_int;
  logic ready;
  logic accept;
  logic last_byte;
  logic [15:0] crc_nxt;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdat_q, wdat_d;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  cfg_ready_timer #(.DLY(READY_DLY)) u_ready (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ready (ready)
  );

  cfg_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (accept),
    .din     (wr_data),
    .crc_nxt (crc_nxt)
  );

  // Window gate: only between ready and completion.
  assign accept    = wr_en & ready & ~done_q;
  assign last_byte = (cnt_q == CNT_W'(IMG_LEN - 1));

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    ok_d   = ok_q;
    we_d   = accept;
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (accept) begin
      cnt_d  = cnt_q + 1'b1;
      addr_d = cnt_q[ADDR_W-1:0];
      wdat_d = wr_data;
      if (last_byte) begin
        done_d = 1'b1;
        ok_d   = (crc_nxt == 16'h0000);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      ok_q   <= ok_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  assign bus_ready  = ready;
  assign load_done  = done_q;
  assign crc_ok     = ok_q;
  assign byte_count = cnt_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdat_q;
endmodule

// File: rtl/cfg_stream_loader_chk.sv
`timescale 1ns/1ps
module cfg_stream_loader_chk #(
  parameter int IMG_LEN = 10496,
  parameter int CNT_W   = 14,
  parameter int ADDR_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              bus_ready,
  input logic              load_done,
  input logic              crc_ok,
  input logic [CNT_W-1:0]  byte_count,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_ready) |-> bus_ready);

  a_r3_no_we_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_ready) |-> !mem_we);

  a_r4_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(wr_en));

  a_r4_addr_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (byte_count == CNT_W'(mem_addr) + 1'b1));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= CNT_W'(IMG_LEN));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count == $past(byte_count)) || (byte_count == $past(byte_count) + 1'b1));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_done) |-> load_done);

  a_r6_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (byte_count == CNT_W'(IMG_LEN)));

  a_r7_no_we_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_done) |-> !mem_we);

  a_r8_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> load_done);

  a_r9_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_done) |-> $stable(crc_ok));
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(
  .IMG_LEN (IMG_LEN),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .bus_ready  (bus_ready),
  .load_done  (load_done),
  .crc_ok     (crc_ok),
  .byte_count (byte_count),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/cfg_stream_loader_tb.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb;
  localparam int IMG_LEN = 10496;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        bus_ready, load_done, crc_ok, mem_we;
  logic [13:0] byte_count, mem_addr;
  logic [7:0]  mem_wdata;

  int n_run;
  int n_fail;
  bit finished;

  cfg_stream_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bus_ready(bus_ready), .load_done(load_done), .crc_ok(crc_ok),
    .byte_count(byte_count), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[15] ^ b[k];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [7:0] gen_byte(input int i);
    int v;
    v = i * 37 + (i >> 8);
    return v[7:0] ^ 8'hC3;
  endfunction

  // Reset, then ready timing with strobes offered during the delay.
  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(!bus_ready && !load_done && !crc_ok && !mem_we, tag, "flags in reset",
        {bus_ready, load_done, crc_ok, mem_we}, 0);
    chk(byte_count == 0, tag, "count in reset", byte_count, 0);
    rst_n = 1'b1;
    wr_en = 1'b1; wr_data = 8'hA5;
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk);
      chk(!bus_ready, "R2", "ready before 6th edge", bus_ready, 0);
      chk(byte_count == 0 && !mem_we, "R3", "write before ready", byte_count, 0);
    end
    @(negedge clk);
    chk(bus_ready, "R2", "ready after 6th edge", bus_ready, 1);
    chk(byte_count == 0 && !mem_we, "R3", "write at ready edge", byte_count, 0);
    chk(!load_done && !crc_ok, tag, "flags after release", {load_done, crc_ok}, 0);
    wr_en = 1'b0;
  endtask

  // Stream the whole image; corrupt_at < 0 means a clean image.
  task automatic run_load(input int corrupt_at, input bit gaps, input bit exp_ok);
    logic [15:0] crc;
    logic [7:0]  b;
    int errs;
    errs = 0;
    crc  = 16'hFFFF;
    @(negedge clk);
    for (int i = 0; i < IMG_LEN; i++) begin
      if (i < IMG_LEN - 2) begin
        b   = gen_byte(i);
        crc = ref_crc(crc, b);
      end else if (i == IMG_LEN - 2) b = crc[15:8];
      else                           b = crc[7:0];
      if (i == corrupt_at) b = b ^ 8'h5A;
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      if (!(mem_we && mem_addr == i[13:0] && mem_wdata == b && byte_count == 14'(i + 1))) begin
        errs++;
        chk(1'b0, "R4", "memory write / count", byte_count, i + 1);
      end
      if (load_done != (i == IMG_LEN - 1)) begin
        errs++;
        chk(1'b0, "R6", "load_done timing", load_done, (i == IMG_LEN - 1));
      end
      if (gaps && (i % 5 == 4) && i != IMG_LEN - 1) begin
        wr_en = 1'b0;
        @(negedge clk);
        if (mem_we || byte_count != 14'(i + 1)) begin
          errs++;
          chk(1'b0, "R11", "idle cycle counted", byte_count, i + 1);
        end
      end
    end
    wr_en = 1'b0;
    chk(errs == 0, "R4", "stream errors", errs, 0);
    chk(byte_count == IMG_LEN, "R5", "final count", byte_count, IMG_LEN);
    chk(load_done, "R6", "load_done at end", load_done, 1);
    if (exp_ok) chk(crc_ok, "R8", "verdict clean image", crc_ok, 1);
    else        chk(!crc_ok, "R9", "verdict corrupted image", crc_ok, 0);
  endtask

  task automatic after_done(input bit exp_ok);
    wr_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wr_data = 8'(k * 17);
      @(negedge clk);
      chk(!mem_we, "R7", "mem_we after done", mem_we, 0);
      chk(byte_count == IMG_LEN, "R5", "count saturates", byte_count, IMG_LEN);
      chk(crc_ok == exp_ok, "R9", "verdict held", crc_ok, exp_ok);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    do_reset("R1");
    run_load(-1, 1'b1, 1'b1);
    after_done(1'b1);
    do_reset("R10");
    run_load(4321, 1'b0, 1'b0);
    after_done(1'b0);
    do_reset("R10");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule